// File: doc/BRIEF.md
# Iterative Radix-2 Number Theoretic Transform Engine

This block computes a forward or inverse number theoretic transform of length N = 2^LOG_N over the integers modulo an odd prime p of up to 32 bits. It holds the coefficients in an internal register array and walks them with a single radix-2 butterfly whose modular multiplier is a three-stage Barrett pipeline. The host supplies the prime p, the Barrett constant floor(2^64 / p) and the value N^-1 mod p as static inputs. While the engine is idle, the host writes coefficients and a twiddle table through one write port. It then pulses `start` together with a direction bit and an optional scaling bit, waits for `done`, and reads the results back combinationally by address.

A run has three parts. First the coefficients are reordered into bit-reversed index order by in-place swaps, one index per cycle. Next come LOG_N butterfly passes. In pass s the span is M = 2^(s+1): the pairs (j+i, j+i+M/2) are updated with the twiddle w^(i·N/M). Each pass issues N/2 butterflies back to back and then waits until the multiplier pipeline is empty before the next pass begins. The inverse direction runs the same sequence but takes its twiddles from a second table region. If scaling is requested, a last pass multiplies every coefficient by N^-1. A linear product of two length-N/2 inputs is formed by zero-filling the upper half of each buffer before the forward transforms.

The controller is a state machine with these states:
- `S_IDLE`: goes to `S_PERM` on `start`.
- `S_PERM`: goes to `S_BFLY` after index N-1.
- `S_BFLY`: goes to `S_DRAIN` after butterfly N/2-1.
- `S_DRAIN`: once the pipeline is empty, goes to `S_BFLY` (next pass), to `S_SCALE` (last pass of an inverse run with scaling), or to `S_DONE`.
- `S_SCALE`: goes to `S_FLUSH` after index N-1.
- `S_FLUSH`: goes to `S_DONE` once the pipeline is empty.
- `S_DONE`: goes to `S_IDLE` after one cycle.

Top module: `ntt_engine`

## Requirements
- R1: After reset, `busy` and `done` are both low.
- R2: A write with `wr_twiddle`=0 stores `wr_data` as coefficient `wr_addr`. A write with `wr_twiddle`=1 stores a twiddle: address k < N/2 holds w^k and address N/2+k holds w^-k. Writes are accepted only while `busy` is low and are ignored during a run.
- R3: A run with `inverse`=0 replaces coefficients a_j (natural order, values below p) with X_i = Σ_j a_j·w^(i·j mod N) mod p, in natural order. This holds for w of order exactly N, and the bit-reversal (for N=16, index 12 is exchanged with index 3) is done internally.
- R4: A run with `inverse`=1 and `scale_en`=0 uses the w^-k region. Applied to a forward result, it leaves N·a_j mod p.
- R5: A run with `inverse`=1 and `scale_en`=1 also multiplies every coefficient by `n_inv`, so forward followed by inverse gives back the original input. In a forward run `scale_en` has no effect.
- R6: Every stored result is fully reduced (below p), including for p above 2^31 and inputs equal to p-1. This relies on `barrett_mu` = floor(2^64/p).
- R7: A `start` pulse while `busy` is high is ignored: the run in progress and its direction are unaffected.
- R8: `done` is high for exactly one cycle at the end of a run, and `busy` is low in the cycle after it.
- R9: A butterfly pass starts only when the multiplier pipeline holds no pending write-back, and no butterfly reads a location that is awaiting write-back.
- R10: Zero-filling the upper N/2 entries of two inputs, transforming both, multiplying the results point by point and running the scaled inverse gives their linear convolution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_twiddle | input | 1 | Write target: 0 coefficient, 1 twiddle table |
| wr_addr | input | LOG_N | Write address |
| wr_data | input | W | Write data |
| rd_addr | input | LOG_N | Coefficient read address |
| rd_data | output | W | Coefficient at `rd_addr` (combinational) |
| modulus | input | W | Prime p |
| barrett_mu | input | 2W | floor(2^64 / p) |
| n_inv | input | W | N^-1 mod p |
| start | input | 1 | Begin a run (sampled only when idle) |
| inverse | input | 1 | Direction: 0 forward, 1 inverse |
| scale_en | input | 1 | Apply N^-1 scaling at the end of an inverse run |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The following are checked on every cycle:
- `done` is a single-cycle pulse and is followed by idle.
- A `start` during a run cannot end or restart it.
- The pass index moves only when the multiplier pipeline is empty.
- The write-back addresses never match the butterfly being issued.
- Every multiplier result and every butterfly output is below p.

The arithmetic itself is shown only by the scenarios: the match of each forward output with a direct quadratic sum, the N-fold and the scaled inverse round trips, and the convolution built from zero-padded inputs. The same scenarios show the effect of the twiddle regions and that writes and a second `start` made during a run are ignored.

// File: rtl/ntt_pkg.sv
package ntt_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_PERM,
        S_BFLY,
        S_DRAIN,
        S_SCALE,
        S_FLUSH,
        S_DONE
    } ntt_state_t;
endpackage

// File: rtl/ntt_modmul.sv
// Three-stage Barrett modular multiplier with a sideband tag.
module ntt_modmul #(
    parameter int W     = 32,
    parameter int TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [W-1:0]     op_a,
    input  logic [W-1:0]     op_b,
    input  logic [TAG_W-1:0] tag_in,
    input  logic [W-1:0]     modulus,
    input  logic [2*W-1:0]   mu,
    output logic             out_valid,
    output logic [W-1:0]     result,
    output logic [TAG_W-1:0] tag_out,
    output logic             pipe_busy
);
    localparam int PW = 2 * W;

    logic             v1, v2;
    logic [PW-1:0]    x1, x2, q2;
    logic [TAG_W-1:0] t1, t2;
    logic [PW-1:0]    prod;
    logic [2*PW-1:0]  qfull;
    logic [PW-1:0]    pm, qp, r_raw, r_a, r_b;

    assign prod  = {{W{1'b0}}, op_a} * {{W{1'b0}}, op_b};
    assign qfull = {{PW{1'b0}}, x1} * {{PW{1'b0}}, mu};
    assign pm    = {{W{1'b0}}, modulus};
    assign qp    = q2 * pm;

    always_comb begin
        r_raw = x2 - qp;
        r_a   = (r_raw >= pm) ? r_raw - pm : r_raw;
        r_b   = (r_a >= pm) ? r_a - pm : r_a;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1        <= 1'b0;
            v2        <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            v1        <= in_valid;
            v2        <= v1;
            out_valid <= v2;
        end
        x1      <= prod;
        t1      <= tag_in;
        x2      <= x1;
        q2      <= PW'(qfull >> PW);
        t2      <= t1;
        result  <= W'(r_b);
        tag_out <= t2;
    end

    assign pipe_busy = v1 | v2 | out_valid;
endmodule

// File: rtl/ntt_addsub.sv
// Butterfly output stage: e + t and e - t modulo p, both inputs below p.
module ntt_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] e_val,
    input  logic [W-1:0] t_val,
    input  logic [W-1:0] modulus,
    output logic [W-1:0] upper,
    output logic [W-1:0] lower
);
    logic [W:0] sum, diff, m_ext;

    always_comb begin
        m_ext = {1'b0, modulus};
        sum   = {1'b0, e_val} + {1'b0, t_val};
        diff  = {1'b0, e_val} - {1'b0, t_val};
        upper = W'((sum >= m_ext) ? sum - m_ext : sum);
        lower = W'((e_val < t_val) ? diff + m_ext : diff);
    end
endmodule

// File: rtl/ntt_addr_gen.sv
// Maps a butterfly number within a pass to its pair of indices and twiddle.
module ntt_addr_gen #(
    parameter int LOG_N = 4,
    parameter int SW    = 2
) (
    input  logic [SW-1:0]    stage,
    input  logic [LOG_N-2:0] bfly,
    output logic [LOG_N-1:0] idx_u,
    output logic [LOG_N-1:0] idx_l,
    output logic [LOG_N-2:0] tw_k
);
    logic [LOG_N-1:0] bf, half_v, mask, i_v, j_v, tw_full;
    logic [SW:0]      sh;

    always_comb begin
        bf      = {1'b0, bfly};
        half_v  = LOG_N'(1) << stage;
        mask    = half_v - LOG_N'(1);
        i_v     = bf & mask;
        j_v     = (bf >> stage) << ({1'b0, stage} + (SW+1)'(1));
        idx_u   = j_v + i_v;
        idx_l   = idx_u + half_v;
        sh      = (SW+1)'(LOG_N - 1) - {1'b0, stage};
        tw_full = i_v << sh;
        tw_k    = (LOG_N-1)'(tw_full);
    end
endmodule

// File: rtl/ntt_engine.sv
module ntt_engine
    import ntt_pkg::*;
#(
    parameter int LOG_N = 4,
    parameter int W     = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_twiddle,
    input  logic [LOG_N-1:0] wr_addr,
    input  logic [W-1:0]     wr_data,
    input  logic [LOG_N-1:0] rd_addr,
    output logic [W-1:0]     rd_data,
    input  logic [W-1:0]     modulus,
    input  logic [2*W-1:0]   barrett_mu,
    input  logic [W-1:0]     n_inv,
    input  logic             start,
    input  logic             inverse,
    input  logic             scale_en,
    output logic             busy,
    output logic             done
);
    localparam int N     = 1 << LOG_N;
    localparam int SW    = (LOG_N > 2) ? $clog2(LOG_N) : 1;
    localparam int TAG_W = 1 + W + 2 * LOG_N;
    localparam logic [LOG_N-1:0] CNT_LAST   = LOG_N'(N - 1);
    localparam logic [LOG_N-1:0] BFLY_LAST  = LOG_N'(N / 2 - 1);
    localparam logic [SW-1:0]    STAGE_LAST = SW'(LOG_N - 1);

    ntt_state_t state, state_nx;

    logic [W-1:0]     coef [N];
    logic [W-1:0]     twd  [N];
    logic [LOG_N-1:0] cnt;
    logic [SW-1:0]    stage;
    logic             inv_r, scale_r;
    logic [LOG_N-1:0] rev_idx;

    // Butterfly addressing
    logic [LOG_N-1:0] idx_u, idx_l;
    logic [LOG_N-2:0] tw_k;

    // Multiplier interface
    logic             mm_in_valid, mm_out_valid, mm_busy;
    logic [W-1:0]     mm_a, mm_b, mm_res;
    logic [TAG_W-1:0] mm_tag_in, mm_tag_out;

    // Write-back fields
    logic             wb_scale;
    logic [W-1:0]     wb_e;
    logic [LOG_N-1:0] wb_ia, wb_ib;
    logic [W-1:0]     bf_up, bf_lo;

    logic             in_scale;

    ntt_addr_gen #(.LOG_N(LOG_N), .SW(SW)) u_addr (
        .stage (stage),
        .bfly  (cnt[LOG_N-2:0]),
        .idx_u (idx_u),
        .idx_l (idx_l),
        .tw_k  (tw_k)
    );

    always_comb begin
        for (int b = 0; b < LOG_N; b++) begin
            rev_idx[b] = cnt[LOG_N-1-b];
        end
    end

    assign in_scale    = (state == S_SCALE);
    assign mm_in_valid = (state == S_BFLY) || in_scale;
    assign mm_a        = in_scale ? coef[cnt] : coef[idx_l];
    assign mm_b        = in_scale ? n_inv : twd[{inv_r, tw_k}];
    assign mm_tag_in   = {in_scale, coef[idx_u], (in_scale ? cnt : idx_u), idx_l};

    ntt_modmul #(.W(W), .TAG_W(TAG_W)) u_mul (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (mm_in_valid),
        .op_a      (mm_a),
        .op_b      (mm_b),
        .tag_in    (mm_tag_in),
        .modulus   (modulus),
        .mu        (barrett_mu),
        .out_valid (mm_out_valid),
        .result    (mm_res),
        .tag_out   (mm_tag_out),
        .pipe_busy (mm_busy)
    );

    assign {wb_scale, wb_e, wb_ia, wb_ib} = mm_tag_out;

    ntt_addsub #(.W(W)) u_bfly (
        .e_val   (wb_e),
        .t_val   (mm_res),
        .modulus (modulus),
        .upper   (bf_up),
        .lower   (bf_lo)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (start) state_nx = S_PERM;
            S_PERM:  if (cnt == CNT_LAST) state_nx = S_BFLY;
            S_BFLY:  if (cnt == BFLY_LAST) state_nx = S_DRAIN;
            S_DRAIN: if (!mm_busy) begin
                         if (stage != STAGE_LAST)   state_nx = S_BFLY;
                         else if (inv_r && scale_r) state_nx = S_SCALE;
                         else                       state_nx = S_DONE;
                     end
            S_SCALE: if (cnt == CNT_LAST) state_nx = S_FLUSH;
            S_FLUSH: if (!mm_busy) state_nx = S_DONE;
            S_DONE:  state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy = (state != S_IDLE);
        done = (state == S_DONE);
    end

    // Run counters and latched run options
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            stage   <= '0;
            inv_r   <= 1'b0;
            scale_r <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    cnt     <= '0;
                    stage   <= '0;
                    inv_r   <= inverse;
                    scale_r <= scale_en;
                end
                S_PERM, S_SCALE: cnt <= cnt + LOG_N'(1);
                S_BFLY:  cnt <= (cnt == BFLY_LAST) ? '0 : cnt + LOG_N'(1);
                S_DRAIN: if (!mm_busy && stage != STAGE_LAST) stage <= stage + SW'(1);
                default: ;
            endcase
        end
    end

    // Coefficient storage: host load, permutation swaps, write-back
    always_ff @(posedge clk) begin
        if (wr_en && !wr_twiddle && state == S_IDLE) begin
            coef[wr_addr] <= wr_data;
        end
        if (state == S_PERM && rev_idx > cnt) begin
            coef[cnt]     <= coef[rev_idx];
            coef[rev_idx] <= coef[cnt];
        end
        if (mm_out_valid) begin
            if (wb_scale) begin
                coef[wb_ia] <= mm_res;
            end else begin
                coef[wb_ia] <= bf_up;
                coef[wb_ib] <= bf_lo;
            end
        end
    end

    // Twiddle storage: forward region low half, inverse region high half
    always_ff @(posedge clk) begin
        if (wr_en && wr_twiddle && state == S_IDLE) begin
            twd[wr_addr] <= wr_data;
        end
    end

    assign rd_data = coef[rd_addr];
endmodule

// File: rtl/ntt_engine_chk.sv
module ntt_engine_chk #(
    parameter int LOG_N = 4,
    parameter int W     = 32,
    parameter int SW    = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [SW-1:0]    stage,
    input logic             mm_busy,
    input logic             mm_in_valid,
    input logic             in_scale,
    input logic             mm_out_valid,
    input logic             wb_scale,
    input logic [LOG_N-1:0] wb_ia,
    input logic [LOG_N-1:0] wb_ib,
    input logic [LOG_N-1:0] idx_u,
    input logic [LOG_N-1:0] idx_l,
    input logic [W-1:0]     mm_res,
    input logic [W-1:0]     bf_up,
    input logic [W-1:0]     bf_lo,
    input logic [W-1:0]     modulus
);
    // R8: single-cycle completion pulse
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: idle right after completion
    a_r8_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R7: a start during a run neither ends nor restarts it
    a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && start) |=> busy);

    // R9: pass index advances only with an empty multiplier pipeline
    a_r9_drain_before_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (stage != $past(stage)) |-> !$past(mm_busy));

    // R9: no butterfly reads a location being written back
    a_r9_no_pending_read: assert property (@(posedge clk) disable iff (!rst_n)
        (mm_in_valid && !in_scale && mm_out_valid && !wb_scale) |->
        (wb_ia != idx_u && wb_ia != idx_l && wb_ib != idx_u && wb_ib != idx_l));

    // R6: multiplier result reduced
    a_r6_mul_reduced: assert property (@(posedge clk) disable iff (!rst_n)
        mm_out_valid |-> (mm_res < modulus));

    // R6: butterfly outputs reduced
    a_r6_bfly_reduced: assert property (@(posedge clk) disable iff (!rst_n)
        (mm_out_valid && !wb_scale) |-> (bf_up < modulus && bf_lo < modulus));
endmodule

bind ntt_engine ntt_engine_chk #(.LOG_N(LOG_N), .W(W), .SW(SW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .busy         (busy),
    .done         (done),
    .stage        (stage),
    .mm_busy      (mm_busy),
    .mm_in_valid  (mm_in_valid),
    .in_scale     (in_scale),
    .mm_out_valid (mm_out_valid),
    .wb_scale     (wb_scale),
    .wb_ia        (wb_ia),
    .wb_ib        (wb_ib),
    .idx_u        (idx_u),
    .idx_l        (idx_l),
    .mm_res       (mm_res),
    .bf_up        (bf_up),
    .bf_lo        (bf_lo),
    .modulus      (modulus)
);

// File: tb/ntt_engine_test.sv
module ntt_engine_test;
    localparam int CLK_PERIOD = 10;
    localparam int LOG_N = 4;
    localparam int N = 1 << LOG_N;
    localparam int W = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, wr_twiddle = 1'b0;
    logic [LOG_N-1:0] wr_addr = '0, rd_addr = '0;
    logic [W-1:0] wr_data = '0, modulus = 32'd97, n_inv = '0;
    logic [2*W-1:0] barrett_mu = '0;
    logic start = 1'b0, inverse = 1'b0, scale_en = 1'b0;
    logic [W-1:0] rd_data;
    logic busy, done;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    logic [31:0] a_in [N];
    logic [31:0] b_in [N];
    logic [31:0] ref_v [N];
    logic [31:0] got [N];
    logic [31:0] got_b [N];
    logic [31:0] wpow [N];
    logic [31:0] cur_p, cur_w, cur_winv, cur_ninv;
    logic [31:0] rng = 32'h1234_5679;

    always #(CLK_PERIOD/2) clk = ~clk;

    ntt_engine #(.LOG_N(LOG_N), .W(W)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_twiddle(wr_twiddle),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .modulus(modulus), .barrett_mu(barrett_mu), .n_inv(n_inv),
        .start(start), .inverse(inverse), .scale_en(scale_en),
        .busy(busy), .done(done)
    );

    function automatic logic [31:0] mulm(input logic [31:0] a, input logic [31:0] b,
                                         input logic [31:0] p);
        logic [63:0] t;
        t = {32'd0, a} * {32'd0, b};
        return 32'(t % {32'd0, p});
    endfunction

    function automatic logic [31:0] addm(input logic [31:0] a, input logic [31:0] b,
                                         input logic [31:0] p);
        logic [32:0] s;
        s = {1'b0, a} + {1'b0, b};
        if (s >= {1'b0, p}) s = s - {1'b0, p};
        return 32'(s);
    endfunction

    function automatic logic [31:0] powm(input logic [31:0] b, input logic [31:0] e,
                                         input logic [31:0] p);
        logic [31:0] r, x, k;
        r = 32'd1; x = b; k = e;
        while (k != 0) begin
            if (k[0]) r = mulm(r, x, p);
            x = mulm(x, x, p);
            k = k >> 1;
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        vectors++;
        if (act !== expv) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    function automatic logic [31:0] next_rand(input logic [31:0] s);
        logic [31:0] x;
        x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    task automatic write_word(input logic tw, input int addr, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_twiddle = tw; wr_addr = LOG_N'(addr); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load_coefs(input logic [31:0] v [N]);
        for (int k = 0; k < N; k++) write_word(1'b0, k, v[k]);
    endtask

    task automatic read_all(output logic [31:0] v [N]);
        for (int k = 0; k < N; k++) begin
            rd_addr = LOG_N'(k);
            #1;
            v[k] = rd_data;
        end
    endtask

    task automatic set_prime(input logic [31:0] p, input logic [31:0] g);
        logic [64:0] two64;
        two64 = 65'h1 << 64;
        cur_p = p;
        cur_w = powm(g, (p - 32'd1) / N, p);
        cur_winv = powm(cur_w, p - 32'd2, p);
        cur_ninv = powm(32'(N), p - 32'd2, p);
        modulus = p;
        n_inv = cur_ninv;
        barrett_mu = 64'(two64 / {33'd0, p});
        for (int k = 0; k < N; k++) wpow[k] = powm(cur_w, 32'(k), p);
        for (int k = 0; k < N/2; k++) begin
            write_word(1'b1, k, wpow[k]);
            write_word(1'b1, N/2 + k, powm(cur_winv, 32'(k), p));
        end
    endtask

    task automatic issue_start(input logic inv, input logic sc);
        @(negedge clk);
        start = 1'b1; inverse = inv; scale_en = sc;
        @(negedge clk);
        start = 1'b0; inverse = 1'b0; scale_en = 1'b0;
    endtask

    task automatic wait_done();
        int guard;
        guard = 0;
        while (!done && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        check("R8 done reached", {31'd0, done}, 32'd1);
        @(negedge clk);
        check("R8 done single cycle", {31'd0, done}, 32'd0);
        check("R8 idle after done", {31'd0, busy}, 32'd0);
    endtask

    task automatic direct_ntt(input logic [31:0] v [N], output logic [31:0] r [N]);
        for (int i = 0; i < N; i++) begin
            logic [31:0] acc;
            acc = 32'd0;
            for (int j = 0; j < N; j++) acc = addm(acc, mulm(v[j], wpow[(i * j) % N], cur_p), cur_p);
            r[i] = acc;
        end
    endtask

    task automatic fill_pattern(input int pat);
        for (int k = 0; k < N; k++) begin
            case (pat)
                0: a_in[k] = (k == 12 % N) ? 32'd1 : 32'd0;
                1: a_in[k] = 32'd1;
                2: a_in[k] = 32'(k) % cur_p;
                3: a_in[k] = cur_p - 32'd1;
                default: begin
                    rng = next_rand(rng);
                    a_in[k] = rng % cur_p;
                end
            endcase
        end
    endtask

    task automatic prime_sweep(input logic [31:0] p, input logic [31:0] g);
        set_prime(p, g);
        for (int pat = 0; pat < 6; pat++) begin
            fill_pattern(pat);
            load_coefs(a_in);
            // R5: scale_en has no effect in a forward run (odd patterns set it)
            issue_start(1'b0, pat[0]);
            wait_done();
            read_all(got);
            direct_ntt(a_in, ref_v);
            for (int k = 0; k < N; k++) check("R3 forward vs direct sum (R6 reduced)", got[k], ref_v[k]);
            if (pat % 2 == 0) begin
                issue_start(1'b1, 1'b1);
                wait_done();
                read_all(got);
                for (int k = 0; k < N; k++) check("R5 scaled round trip", got[k], a_in[k]);
            end else begin
                issue_start(1'b1, 1'b0);
                wait_done();
                read_all(got);
                for (int k = 0; k < N; k++) check("R4 unscaled inverse gives N*a", got[k], mulm(a_in[k], 32'(N), cur_p));
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 busy after reset", {31'd0, busy}, 32'd0);
        check("R1 done after reset", {31'd0, done}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy idle", {31'd0, busy}, 32'd0);

        prime_sweep(32'd97, 32'd5);
        prime_sweep(32'd998244353, 32'd3);
        prime_sweep(32'd3221225473, 32'd5);

        // R7 and R2: second start and writes during a run are ignored
        fill_pattern(4);
        load_coefs(a_in);
        issue_start(1'b0, 1'b0);
        repeat (4) @(negedge clk);
        start = 1'b1; inverse = 1'b1; scale_en = 1'b1;
        wr_en = 1'b1; wr_twiddle = 1'b0; wr_addr = '0; wr_data = 32'd7;
        @(negedge clk);
        start = 1'b0; inverse = 1'b0; scale_en = 1'b0;
        wr_twiddle = 1'b1; wr_addr = LOG_N'(1); wr_data = 32'd0;
        @(negedge clk);
        wr_en = 1'b0; wr_twiddle = 1'b0;
        wait_done();
        read_all(got);
        direct_ntt(a_in, ref_v);
        for (int k = 0; k < N; k++) check("R7 R2 run unaffected by busy start/writes", got[k], ref_v[k]);

        // R10: linear product via zero-padded buffers
        set_prime(32'd998244353, 32'd3);
        for (int k = 0; k < N; k++) begin
            rng = next_rand(rng);
            a_in[k] = (k < N/2) ? rng % 32'd1000 : 32'd0;
            rng = next_rand(rng);
            b_in[k] = (k < N/2) ? rng % 32'd1000 : 32'd0;
        end
        load_coefs(a_in);
        issue_start(1'b0, 1'b0);
        wait_done();
        read_all(got);
        load_coefs(b_in);
        issue_start(1'b0, 1'b0);
        wait_done();
        read_all(got_b);
        for (int k = 0; k < N; k++) ref_v[k] = mulm(got[k], got_b[k], cur_p);
        load_coefs(ref_v);
        issue_start(1'b1, 1'b1);
        wait_done();
        read_all(got);
        for (int k = 0; k < N; k++) begin
            logic [31:0] acc;
            acc = 32'd0;
            for (int i = 0; i <= k; i++) acc = addm(acc, mulm(a_in[i], b_in[k - i], cur_p), cur_p);
            check("R10 linear convolution", got[k], acc);
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule